// File: doc/BRIEF.md
# Selectable Multi-Polynomial Parallel CRC

This block computes a cyclic redundancy remainder over a byte stream for the three check lengths used in cellular transport: 8, 16 and 24 bits. Every accepted byte is folded into the remainder in a single clock, eight bits at once. All three generators run on one XOR network. Each bit stage of that network is shared. The active generator only changes which feedback tap, which truncation mask and which polynomial constant the network uses.

A frame opens with a `start` pulse. The same pulse samples the three select lines as the frame's generator choice. Bytes then arrive on a valid/ready stream. The stream offers back-pressure only at frame boundaries. `in_ready` is high while a frame with a legal select code is open, and also in a start cycle whose select code is legal. It drops after the byte marked last has been taken, and it stays low after an illegal select code. A byte is taken only on a cycle where `in_valid` and `in_ready` are both high. The source must hold the byte and its `in_last` flag until that happens.

The remainder is always visible on `crc_out`, right-aligned. `done` marks the cycle after the final byte has been folded in.

Top module: `crc_multi_top`

## Requirements
- R1: The select code is one-hot: sel=3'b001 picks the 8-bit generator 0x9B, sel=3'b010 picks the 16-bit generator 0x1021, and sel=3'b100 picks the 24-bit generator 0x864CFB. The remainder starts at zero, is not inverted, and equals bit-serial polynomial division.
- R2: Each accepted byte advances the remainder by exactly eight message bits, with bit 7 of the byte processed first.
- R3: In the cycle `start` is high, the remainder is cleared and the select code is latched. A byte accepted in that same cycle is folded into the cleared remainder.
- R4: On any cycle without an accepted byte and without `start`, the remainder holds its value.
- R5: If `start` samples a select code that is not one-hot, `err` is high from the next cycle. While `err` is high, `in_ready` is low, `crc_out` reads zero and the remainder stays frozen. A later `start` with a legal code clears `err`.
- R6: `crc_out` is right-aligned. For the 8-bit generator bits 23:8 are zero, and for the 16-bit generator bits 23:16 are zero.
- R7: `done` goes high in the cycle after the byte with `in_last` set is accepted, and stays high until the next `start`. `in_ready` is low from that cycle until the next `start`.
- R8: `in_ready` is high in a start cycle with a one-hot code, and throughout an open frame. A `start` during an open frame restarts the calculation.
- R9: After reset, `crc_out` is zero, `done` and `err` are low, and `in_ready` is low while `start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a frame; clears the remainder and samples `sel` |
| sel | input | 3 | One-hot generator choice (bit0 8-bit, bit1 16-bit, bit2 24-bit) |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_ready | output | 1 | Block will take the offered byte this cycle |
| in_data | input | 8 | Message byte, MSB first |
| in_last | input | 1 | Offered byte is the final one of the frame |
| crc_out | output | 24 | Current remainder, right-aligned |
| done | output | 1 | Frame finished; remainder is final |
| err | output | 1 | Latched select code was not one-hot |

## Verification
Two things can happen in the same cycle: a frame can open, and its first byte can be absorbed. The bench drives `start` together with a valid byte, and it also drives `start` together with a byte flagged last, which is a single-byte frame. A frame can also be restarted while bytes are still flowing. After each such cycle, the bench checks the remainder, `done` and `in_ready` against a bit-serial model. That model clears first and then shifts the byte in. A known 16-bit check value over the ASCII string "123456789" anchors the model.

// File: rtl/crc_multi_pkg.sv
package crc_multi_pkg;
  localparam int CRC_W  = 24;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;

  localparam logic [CRC_W-1:0] GEN_8  = 24'h00009B;
  localparam logic [CRC_W-1:0] GEN_16 = 24'h001021;
  localparam logic [CRC_W-1:0] GEN_24 = 24'h864CFB;

  typedef struct packed {
    logic [CRC_W-1:0] poly;
    logic [CRC_W-1:0] mask;
    logic [CRC_W-1:0] top;
  } gen_cfg_t;

  function automatic logic code_is_onehot(input logic [SEL_W-1:0] s);
    return (s == 3'b001) || (s == 3'b010) || (s == 3'b100);
  endfunction
endpackage

// File: rtl/crc_gen_decode.sv
module crc_gen_decode
  import crc_multi_pkg::*;
(
  input  logic [SEL_W-1:0] code,
  output gen_cfg_t         cfg
);
  always_comb begin
    cfg = '0;
    unique case (code)
      3'b001: begin
        cfg.poly = GEN_8;
        cfg.mask = 24'h0000FF;
        cfg.top  = 24'h000080;
      end
      3'b010: begin
        cfg.poly = GEN_16;
        cfg.mask = 24'h00FFFF;
        cfg.top  = 24'h008000;
      end
      3'b100: begin
        cfg.poly = GEN_24;
        cfg.mask = 24'hFFFFFF;
        cfg.top  = 24'h800000;
      end
      default: cfg = '0;
    endcase
  end
endmodule

// File: rtl/crc_shared_net.sv
module crc_shared_net
  import crc_multi_pkg::*;
#(
  parameter int W  = CRC_W,
  parameter int DW = DATA_W
) (
  input  logic [W-1:0]  rem_in,
  input  logic [DW-1:0] data,
  input  gen_cfg_t      cfg,
  output logic [W-1:0]  rem_out
);
  logic [DW:0][W-1:0] stage;

  assign stage[0] = rem_in;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic fb;
    assign fb = (|(stage[i] & cfg.top)) ^ data[DW-1-i];
    assign stage[i+1] = ((stage[i] << 1) & cfg.mask) ^ ({W{fb}} & cfg.poly);
  end

  assign rem_out = stage[DW];
endmodule

// File: rtl/crc_frame_ctrl.sv
module crc_frame_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic code_ok,
  input  logic in_valid,
  input  logic in_last,
  output logic in_ready,
  output logic accept,
  output logic err,
  output logic done
);
  logic open_q;

  assign in_ready = start ? code_ok : (open_q && !err);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      err    <= 1'b0;
      done   <= 1'b0;
    end else begin
      if (start) begin
        err    <= !code_ok;
        open_q <= code_ok;
        done   <= 1'b0;
      end
      if (accept && in_last) begin
        open_q <= 1'b0;
        done   <= 1'b1;
      end
    end
  end

  assert_err_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |-> !in_ready);

  assert_done_follows_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_last) |=> (done && (start || !in_ready)));

  assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !(accept && in_last)) |=> !done);
endmodule

// File: rtl/crc_multi_top.sv
module crc_multi_top
  import crc_multi_pkg::*;
#(
  parameter int W  = CRC_W,
  parameter int DW = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic             in_last,
  output logic [W-1:0]     crc_out,
  output logic             done,
  output logic             err
);
  logic [W-1:0]     rem_q;
  logic [W-1:0]     net_in;
  logic [W-1:0]     net_out;
  logic [SEL_W-1:0] code_q;
  logic [SEL_W-1:0] code_eff;
  logic             accept;
  gen_cfg_t         cfg_eff;
  gen_cfg_t         cfg_q;

  assign code_eff = start ? sel : code_q;
  assign net_in   = start ? '0 : rem_q;

  crc_gen_decode u_dec_eff (.code(code_eff), .cfg(cfg_eff));
  crc_gen_decode u_dec_q   (.code(code_q),   .cfg(cfg_q));

  crc_shared_net #(.W(W), .DW(DW)) u_net (
    .rem_in (net_in),
    .data   (in_data),
    .cfg    (cfg_eff),
    .rem_out(net_out)
  );

  crc_frame_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .code_ok (code_is_onehot(sel)),
    .in_valid(in_valid),
    .in_last (in_last),
    .in_ready(in_ready),
    .accept  (accept),
    .err     (err),
    .done    (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      code_q <= '0;
    end else begin
      if (start) code_q <= sel;
      if (accept)     rem_q <= net_out;
      else if (start) rem_q <= '0;
    end
  end

  assign crc_out = rem_q & cfg_q.mask;

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !accept) |=> $stable(crc_out));

  assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !accept) |=> (crc_out == '0));

  assert_err_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (crc_out == '0));

  assert_short_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == 3'b001) |-> (rem_q[W-1:8] == '0));

  assert_mid_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == 3'b010) |-> (rem_q[W-1:16] == '0));
endmodule

// File: tb/crc_multi_top_tb_top.sv
module crc_multi_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  sel = 3'b000;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        in_last = 1'b0;
  logic [23:0] crc_out;
  logic        done;
  logic        err;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  // reference state
  int unsigned m_crc = 0;
  int unsigned m_poly = 0;
  int          m_w = 0;
  bit          m_open = 0;
  bit          m_err = 0;
  bit          m_done = 0;

  always #2.5 clk = ~clk;

  crc_multi_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .crc_out(crc_out), .done(done), .err(err)
  );

  function automatic bit legal(input logic [2:0] s);
    return s == 3'b001 || s == 3'b010 || s == 3'b100;
  endfunction

  function automatic int unsigned serial_byte(input int unsigned c, input int w,
                                              input int unsigned p, input logic [7:0] d);
    int unsigned r = c;
    int unsigned msk = (w == 0) ? 0 : ((1 << w) - 1);
    for (int b = 7; b >= 0; b--) begin
      bit fb;
      fb = ((w == 0) ? 1'b0 : r[w-1]) ^ d[b];
      r = (r << 1) & msk;
      if (fb) r = r ^ p;
    end
    return r;
  endfunction

  function automatic bit m_ready();
    return start ? legal(sel) : (m_open && !m_err);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_outputs(input string tag);
    check(crc_out == m_crc[23:0], tag, "crc_out", crc_out, m_crc);
    check(done == m_done, tag, "done", done, m_done);
    check(err == m_err, tag, "err", err, m_err);
  endtask

  // drive one cycle of stimulus, check ready, advance, check registered outputs
  task automatic beat(input bit s, input logic [2:0] sl, input bit v,
                      input logic [7:0] d, input bit l, input string tag);
    bit acc;
    start = s; sel = sl; in_valid = v; in_data = d; in_last = l;
    #1;
    check(in_ready == m_ready(), tag, "in_ready", in_ready, m_ready());
    acc = v && m_ready();
    @(posedge clk);
    if (s) begin
      m_err  = !legal(sl);
      m_open = legal(sl);
      m_done = 0;
      m_crc  = 0;
      case (sl)
        3'b001: begin m_w = 8;  m_poly = 32'h9B;     end
        3'b010: begin m_w = 16; m_poly = 32'h1021;   end
        3'b100: begin m_w = 24; m_poly = 32'h864CFB; end
        default: begin m_w = 0; m_poly = 0; end
      endcase
    end
    if (acc) begin
      m_crc = serial_byte(m_crc, m_w, m_poly, d);
      if (l) begin m_open = 0; m_done = 1; end
    end
    @(negedge clk);
    compare_outputs(tag);
  endtask

  task automatic idle(input string tag);
    beat(0, 3'b000, 0, 8'h00, 0, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    string msg;
    msg = "123456789";
    repeat (3) @(negedge clk);
    // R9 reset state
    check(crc_out == 0 && done == 0 && err == 0 && in_ready == 0, "R9", "reset outputs",
          {crc_out, done, err, in_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle("R9");

    // R1 R3: 16-bit known value, start together with first byte
    for (int i = 0; i < 9; i++)
      beat(i == 0, 3'b010, 1, msg[i], i == 8, "R3");
    check(crc_out == 24'h0031C3, "R1", "16-bit check value", crc_out, 24'h31C3);
    check(crc_out[23:16] == 0, "R6", "16-bit upper zero", crc_out, m_crc);
    idle("R7");
    // R7: bytes after last are refused
    beat(0, 3'b000, 1, 8'hA5, 0, "R7");

    // R2 R4: 8-bit frame with gaps
    beat(1, 3'b001, 0, 8'h00, 0, "R3");
    for (int i = 0; i < 12; i++) begin
      beat(0, 3'b000, 1, 8'(i * 37 + 5), i == 11, "R2");
      if (i % 3 == 0) beat(0, 3'b000, 0, 8'hFF, 0, "R4");
    end
    check(crc_out[23:8] == 0, "R6", "8-bit upper zero", crc_out, m_crc);

    // R1: 24-bit frame over the string
    for (int i = 0; i < 9; i++)
      beat(i == 0, 3'b100, 1, msg[i], i == 8, "R1");
    idle("R7");

    // R5: illegal code
    beat(1, 3'b011, 1, 8'h12, 0, "R5");
    beat(0, 3'b000, 1, 8'h34, 0, "R5");
    beat(0, 3'b000, 1, 8'h56, 1, "R5");
    beat(1, 3'b000, 0, 8'h00, 0, "R5");
    idle("R5");
    // recovery with legal code
    beat(1, 3'b100, 1, 8'hC3, 0, "R5");
    beat(0, 3'b000, 1, 8'h3C, 0, "R2");

    // R8: restart mid-frame with a different generator
    beat(1, 3'b001, 1, 8'h77, 0, "R8");
    beat(0, 3'b000, 1, 8'h88, 0, "R8");
    beat(0, 3'b000, 1, 8'h99, 1, "R8");
    idle("R7");

    // R7: single-byte frame, start and last together
    beat(1, 3'b010, 1, 8'hE1, 1, "R7");
    beat(0, 3'b000, 1, 8'h00, 0, "R7");
    idle("R4");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule